// File: doc/BRIEF.md
# Encoded Interrupt Level Input Filter

This block sits between four external interrupt-request pins and a processor's interrupt controller. It delivers a filtered request flag and a 4-bit priority level. The pins are active-low. They pass through a synchroniser first. A debounce stage then samples them on a sampling tick. A pin pattern replaces the held state only after the same value has been seen on three samples in a row, so brief glitches never reach the output.

The sampling tick comes from one of two enables. While the bus clock runs, `bus_tick` is used. While `standby` is high, a slow tick derived from a 32.768 kHz source is used instead. Changing `standby` restarts the stability count.

The filtered pattern is read in one of two ways:
- **Encoded mode:** the four pins form one inverted level code.
- **Independent mode:** each pin is a separate request whose priority comes from a 4-bit field of `prio_cfg`. The highest programmed priority among the asserted pins wins.

The block never touches the processor's interrupt mask.

Top module: `irq_level_filter`

## Requirements
- R1: After reset the held pattern is all ones, so `req_valid` is 0 and `req_level` is 0 while `indep_mode` is 0.
- R2: In encoded mode (`indep_mode` = 0), `req_level` equals 15 minus the held 4-bit pin value (pin 3 is the most significant bit), so pins 0000 give level 15.
- R3: A held pin value of 1111 means no request in encoded mode: `req_valid` = 0 and `req_level` = 0.
- R4: A new pin pattern is accepted only after it has been sampled unchanged on three consecutive sampling ticks; a pattern seen on only one or two ticks never changes the outputs.
- R5: With a sampling tick on every clock cycle, the outputs change on the sixth rising clock edge after a pin change (two synchroniser stages, three samples, one output register).
- R6: While `standby` is 0, samples are taken only in cycles with `bus_tick` high; with `bus_tick` low the outputs hold whatever the pins do.
- R7: While `standby` is 1, samples are taken only in cycles with `slow_tick` high; without slow ticks no pin change is ever accepted.
- R8: In independent mode (`indep_mode` = 1), pin i is asserted when its held value is 0, and its priority is `prio_cfg[4i+3:4i]`; `req_level` is the largest priority among asserted pins and `req_valid` is 1 exactly when that level is nonzero.
- R9: In independent mode an asserted pin whose priority field is 0 is ignored; if it is the only asserted pin, `req_valid` is 0 and `req_level` is 0.
- R10: A change of `standby` clears the stability count in the next cycle, so samples taken before the change do not count toward the three needed afterwards.
- R11: Changes to `indep_mode` or `prio_cfg` reinterpret the already-held pattern in the same cycle, without new sampling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_n | input | 4 | Asynchronous active-low interrupt pins |
| bus_tick | input | 1 | Sample enable used while `standby` is 0 |
| slow_tick | input | 1 | Sample enable used while `standby` is 1 |
| standby | input | 1 | Selects the slow sampling tick |
| indep_mode | input | 1 | 1 = four independent requests, 0 = one encoded level |
| prio_cfg | input | 16 | Four 4-bit priorities; field i at bits 4i+3..4i |
| req_valid | output | 1 | Filtered request present |
| req_level | output | 4 | Priority level of the filtered request |

## Verification
The bench sends pulses of one and two clock cycles to show that they leave the output untouched. A filter with a shorter run length would pass them through as a spurious request. The exact six-edge latency is measured, which exposes a missing or extra synchroniser or output stage. Ticks are withheld in each sampling mode, and two samples are taken just before a `standby` change. A design that ignores the enable, uses the wrong one, or keeps the count across the switch would accept a pattern too early. In independent mode the bench uses a zero-priority pin and changes the priorities live, to catch a wrong maximum, a zero priority that is not ignored, or a result latched too late.

// File: rtl/irq_filt_pkg.sv
package irq_filt_pkg;

    localparam int unsigned PIN_W = 4;
    localparam int unsigned LVL_W = 4;

    typedef logic [PIN_W-1:0] pins_t;
    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        logic   valid;
        level_t level;
    } irq_req_t;

    typedef enum logic {
        SRC_BUS  = 1'b0,
        SRC_SLOW = 1'b1
    } tick_src_e;

    // Encoded pins map to a level by bitwise inversion.
    function automatic level_t code_to_level(pins_t code);
        return level_t'(~code);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    // Idle level of active-low pins is all ones.
    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '1;
        else     stg[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '1;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/irq_debounce.sv
module irq_debounce
    import irq_filt_pkg::*;
#(
    parameter int unsigned SAMPLES = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t din,
    input  logic  bus_tick,
    input  logic  slow_tick,
    input  logic  standby,
    output pins_t held
);
    localparam int unsigned CNT_W = $clog2(SAMPLES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLES);

    tick_src_e        src, src_q;
    logic             tick;
    logic             src_changed;
    pins_t            cand;
    logic [CNT_W-1:0] cnt;

    assign src         = standby ? SRC_SLOW : SRC_BUS;
    assign tick        = (src == SRC_SLOW) ? slow_tick : bus_tick;
    assign src_changed = (src != src_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_BUS;
            cand  <= '1;
            cnt   <= '0;
        end else begin
            src_q <= src;
            if (src_changed) begin
                cnt <= '0;
            end else if (tick) begin
                if (din == cand) begin
                    if (cnt != FULL) cnt <= cnt + 1'b1;
                end else begin
                    cand <= din;
                    cnt  <= CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              held <= '1;
        else if (cnt == FULL) held <= cand;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL); // R4
    AST_ACCEPT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (held != $past(held)) |-> ($past(cnt) == FULL)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick && !src_changed) |=> ($stable(cand) && $stable(cnt))); // R6
    AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        src_changed |=> (cnt == '0)); // R10
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irq_filt_pkg::*;
(
    input  pins_t                    held,
    input  logic                     indep_mode,
    input  logic [PIN_W*LVL_W-1:0]   prio_cfg,
    output irq_req_t                 req
);
    level_t prio [PIN_W];
    level_t best;

    for (genvar i = 0; i < PIN_W; i++) begin : g_field
        assign prio[i] = prio_cfg[i*LVL_W +: LVL_W];
    end

    // Strict compare: lowest pin wins ties; zero priority never wins.
    always_comb begin
        best = '0;
        for (int i = 0; i < PIN_W; i++) begin
            if (!held[i] && (prio[i] > best)) best = prio[i];
        end
    end

    always_comb begin
        req.level = indep_mode ? best : code_to_level(held);
        req.valid = (req.level != '0);
    end
endmodule

// File: rtl/irq_level_filter.sv
module irq_level_filter
    import irq_filt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SAMPLES     = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             pins_n,
    input  logic                   bus_tick,
    input  logic                   slow_tick,
    input  logic                   standby,
    input  logic                   indep_mode,
    input  logic [15:0]            prio_cfg,
    output logic                   req_valid,
    output logic [3:0]             req_level
);
    pins_t    pins_s;
    pins_t    held;
    irq_req_t req;

    irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_n),
        .q_sync  (pins_s)
    );

    irq_debounce #(.SAMPLES(SAMPLES)) u_deb (
        .clk       (clk),
        .rst       (rst),
        .din       (pins_s),
        .bus_tick  (bus_tick),
        .slow_tick (slow_tick),
        .standby   (standby),
        .held      (held)
    );

    irq_level_sel u_sel (
        .held       (held),
        .indep_mode (indep_mode),
        .prio_cfg   (prio_cfg),
        .req        (req)
    );

    assign req_valid = req.valid;
    assign req_level = req.level;

    AST_VALID_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (rst)
        req_valid == (req_level != 4'd0)); // R8
    AST_ENC_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!indep_mode && held == 4'hF) |-> !req_valid); // R3
    AST_NO_TICK_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!standby && !$past(standby) && !$past(bus_tick, 2) && !$past(bus_tick))
        |-> $stable(held)); // R6
endmodule

// File: tb/irq_level_filter_bench.sv
module irq_level_filter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pins_n = 4'hF;
    logic        bus_tick = 1'b1;
    logic        slow_tick = 1'b0;
    logic        standby = 1'b0;
    logic        indep_mode = 1'b0;
    logic [15:0] prio_cfg = 16'h0000;
    logic        req_valid;
    logic [3:0]  req_level;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_level_filter u_irq_level_filter (
        .clk(clk), .rst(rst), .pins_n(pins_n), .bus_tick(bus_tick),
        .slow_tick(slow_tick), .standby(standby), .indep_mode(indep_mode),
        .prio_cfg(prio_cfg), .req_valid(req_valid), .req_level(req_level)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic ev, input logic [3:0] el);
        checks++;
        if (req_valid !== ev || req_level !== el) begin
            failures++;
            $display("FAIL %s: valid=%0b level=%0d expected valid=%0b level=%0d",
                     tag, req_valid, req_level, ev, el);
        end
    endtask

    task automatic settle(input logic [3:0] p);
        pins_n = p;
        wait_cyc(8);
    endtask

    task automatic slow_pulse();
        slow_tick = 1'b1;
        wait_cyc(1);
        slow_tick = 1'b0;
        wait_cyc(1);
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b0, 4'd0);
    endtask

    task automatic t_encoded();
        logic [3:0] vals [5] = '{4'd0, 4'd5, 4'd14, 4'd9, 4'd15};
        foreach (vals[k]) begin
            settle(vals[k]);
            if (vals[k] == 4'hF) check("R3 all ones", 1'b0, 4'd0);
            else check("R2 encoded", 1'b1, 4'd15 - vals[k]);
        end
    endtask

    task automatic t_latency();
        pins_n = 4'd3;
        wait_cyc(5);
        check("R5 before sixth edge", 1'b0, 4'd0);
        wait_cyc(1);
        check("R5 at sixth edge", 1'b1, 4'd12);
        settle(4'hF);
    endtask

    task automatic t_glitch();
        for (int w = 1; w <= 2; w++) begin
            pins_n = 4'd0;
            wait_cyc(w);
            pins_n = 4'hF;
            for (int c = 0; c < 8; c++) begin
                wait_cyc(1);
                check("R4 short glitch", 1'b0, 4'd0);
            end
        end
        pins_n = 4'd0;
        wait_cyc(3);
        pins_n = 4'hF;
        wait_cyc(5);
        check("R4 three samples accepted", 1'b1, 4'd15);
        settle(4'hF);
        check("R4 back to idle", 1'b0, 4'd0);
    endtask

    task automatic t_bus_tick();
        bus_tick = 1'b0;
        pins_n = 4'd5;
        wait_cyc(10);
        check("R6 no bus tick", 1'b0, 4'd0);
        bus_tick = 1'b1;
        wait_cyc(4);
        check("R6 bus tick resumes", 1'b1, 4'd10);
    endtask

    task automatic t_standby();
        standby = 1'b1;
        pins_n = 4'd8;
        wait_cyc(20);
        check("R7 no slow tick", 1'b1, 4'd10);
        repeat (3) slow_pulse();
        check("R7 slow ticks accept", 1'b1, 4'd7);
        standby = 1'b0;
        wait_cyc(6);
        check("R7 back to bus", 1'b1, 4'd7);
    endtask

    task automatic t_switch();
        bus_tick = 1'b0;
        pins_n = 4'd2;
        wait_cyc(4);
        bus_tick = 1'b1;
        wait_cyc(2);
        bus_tick = 1'b0;
        standby = 1'b1;
        wait_cyc(2);
        slow_pulse();
        wait_cyc(4);
        check("R10 count cleared on switch", 1'b1, 4'd7);
        slow_pulse();
        slow_pulse();
        check("R10 accepted after three new samples", 1'b1, 4'd13);
        standby = 1'b0;
        bus_tick = 1'b1;
        wait_cyc(6);
    endtask

    task automatic t_indep();
        prio_cfg = 16'h7093;
        settle(4'hF);
        indep_mode = 1'b1;
        wait_cyc(1);
        check("R8 indep idle", 1'b0, 4'd0);
        settle(4'b1110);
        check("R8 pin0 only", 1'b1, 4'd3);
        settle(4'b1100);
        check("R8 max of pin0 pin1", 1'b1, 4'd9);
        settle(4'b1011);
        check("R9 zero priority pin ignored", 1'b0, 4'd0);
        settle(4'b0011);
        check("R9 pin3 beats zero pin2", 1'b1, 4'd7);
        settle(4'b1001);
        check("R8 pin1 and pin2", 1'b1, 4'd9);
        prio_cfg = 16'h7023;
        wait_cyc(1);
        check("R11 priority change", 1'b1, 4'd2);
        indep_mode = 1'b0;
        wait_cyc(1);
        check("R11 back to encoded", 1'b1, 4'd6);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_encoded();
        t_latency();
        t_glitch();
        t_bus_tick();
        t_standby();
        t_switch();
        t_indep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule